// File: doc/BRIEF.md
# Integer ALU with Overflow Trap Request

This block is the combinational integer execute unit of a 32-bit RISC pipeline. The decode stage feeds it the 6-bit primary opcode and the 6-bit function code of a fixed-format instruction. It also receives two register operands, the 16-bit immediate field and the 5-bit constant shift amount. In the same cycle the block returns the 32-bit result and a trap request for signed overflow.

A trap request depends only on which operation is selected. It never depends on how the operands are meant to be read. The add and subtract forms that trap, and the forms that never trap, give the same bit pattern. Both immediate-add forms sign-extend their constant. The two logical-immediate forms zero-extend theirs. When a trap is requested, the result is still driven but is marked invalid, so writeback can drop it.

Register-file access, exception sequencing after a trap and memory instructions are handled outside this block.

Top module: `int_alu_trap`

## Requirements
- R1: With opcode 0, function codes 0x20 and 0x21 give opnd_a + opnd_b, and 0x22 and 0x23 give opnd_a - opnd_b, in both cases modulo 2^32.
- R2: Function codes 0x20 and 0x22 raise trap_req exactly when the two's-complement sum or difference overflows; 0x21 and 0x23 never raise trap_req.
- R3: Opcode 0x08 gives opnd_a plus the sign-extended immediate and traps on signed overflow; opcode 0x09 gives the same sum and never traps.
- R4: With opcode 0, function codes 0x24, 0x25, 0x26 and 0x27 give the bitwise AND, OR, XOR and NOR of opnd_a and opnd_b.
- R5: Opcode 0x0C (AND) and opcode 0x0D (OR) combine opnd_a with the immediate zero-extended to 32 bits.
- R6: Function code 0x2A (register form) and opcode 0x0A (immediate form, immediate sign-extended) give 1 when opnd_a is less than the second operand as signed values, else 0.
- R7: Opcode 0x0F gives the immediate in bits 31:16 and zeros in bits 15:0, whatever opnd_a is.
- R8: With opcode 0, function code 0x00 shifts opnd_b left, 0x02 shifts it right filling with zeros, and 0x03 shifts it right filling with bit 31, by shamt places (0 to 31).
- R9: result_valid is low exactly when trap_req is high. In that case result still carries the wrapped 32-bit sum or difference.
- R10: An all-zero opcode, function code and shamt gives opnd_b unchanged, with no trap and result_valid high.
- R11: Any opcode or function code not listed above gives result 0, trap_req low and result_valid high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode | input | 6 | Primary opcode field |
| funct | input | 6 | Function code field, decoded when opcode is 0 |
| shamt | input | 5 | Constant shift amount |
| opnd_a | input | 32 | First register operand |
| opnd_b | input | 32 | Second register operand, and the shift source |
| imm | input | 16 | Immediate field |
| result | output | 32 | Operation result |
| trap_req | output | 1 | Signed-overflow trap request |
| result_valid | output | 1 | Low when the result must not be written back |

## Verification
The block holds no state, so any fault in decode, operand extension, the shared adder or a shifter stage shows up at result or trap_req in the same cycle as the stimulus. Each fault is visible only for operand patterns that reach it. An extension fault appears only when immediate bit 15 is set. An overflow fault appears only near 0x7FFFFFFF and 0x80000000. A shifter-stage fault appears only for shift amounts with the matching bit set. For this reason the bench sweeps every pair from a set of corner operands, every shift amount and the corner immediates, and checks each result and flag as it is applied.

// File: rtl/alu_pkg.sv
// Shared encodings and the internal control word for the integer ALU.
// Assumes the 32-bit fixed instruction format with 6-bit opcode/funct fields.
package alu_pkg;
    localparam int OPC_W = 6;

    localparam logic [OPC_W-1:0] OPC_SPECIAL = 6'h00;
    localparam logic [OPC_W-1:0] OPC_ADDI    = 6'h08;
    localparam logic [OPC_W-1:0] OPC_ADDIU   = 6'h09;
    localparam logic [OPC_W-1:0] OPC_SLTI    = 6'h0A;
    localparam logic [OPC_W-1:0] OPC_ANDI    = 6'h0C;
    localparam logic [OPC_W-1:0] OPC_ORI     = 6'h0D;
    localparam logic [OPC_W-1:0] OPC_LUI     = 6'h0F;

    localparam logic [OPC_W-1:0] FN_SLL  = 6'h00;
    localparam logic [OPC_W-1:0] FN_SRL  = 6'h02;
    localparam logic [OPC_W-1:0] FN_SRA  = 6'h03;
    localparam logic [OPC_W-1:0] FN_ADD  = 6'h20;
    localparam logic [OPC_W-1:0] FN_ADDU = 6'h21;
    localparam logic [OPC_W-1:0] FN_SUB  = 6'h22;
    localparam logic [OPC_W-1:0] FN_SUBU = 6'h23;
    localparam logic [OPC_W-1:0] FN_AND  = 6'h24;
    localparam logic [OPC_W-1:0] FN_OR   = 6'h25;
    localparam logic [OPC_W-1:0] FN_XOR  = 6'h26;
    localparam logic [OPC_W-1:0] FN_NOR  = 6'h27;
    localparam logic [OPC_W-1:0] FN_SLT  = 6'h2A;

    typedef enum logic [3:0] {
        K_NONE, K_ARITH, K_AND, K_OR, K_XOR, K_NOR,
        K_SLT, K_HIGH, K_SHL, K_SHR, K_SHRA
    } alu_kind_e;

    typedef struct packed {
        alu_kind_e kind;
        logic      use_imm;   // second operand comes from the immediate
        logic      imm_sext;  // sign-extend (1) or zero-extend (0)
        logic      subtract;  // adder computes a - b
        logic      trap_en;   // signed overflow raises a trap
    } alu_ctrl_t;
endpackage

// File: rtl/alu_decode.sv
// Maps opcode/funct to the internal control word.
// Assumes funct is meaningful only when opcode selects the register group.
module alu_decode
    import alu_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    input  logic [OPC_W-1:0] funct,
    output alu_ctrl_t        ctrl
);
    // Purpose: translate the instruction fields into one control word.
    always_comb begin
        ctrl = '{kind: K_NONE, use_imm: 1'b0, imm_sext: 1'b0,
                 subtract: 1'b0, trap_en: 1'b0};
        unique case (opcode)
            OPC_SPECIAL: begin
                unique case (funct)
                    FN_ADD:  begin ctrl.kind = K_ARITH; ctrl.trap_en = 1'b1; end
                    FN_ADDU: ctrl.kind = K_ARITH;
                    FN_SUB:  begin ctrl.kind = K_ARITH; ctrl.subtract = 1'b1;
                                   ctrl.trap_en = 1'b1; end
                    FN_SUBU: begin ctrl.kind = K_ARITH; ctrl.subtract = 1'b1; end
                    FN_AND:  ctrl.kind = K_AND;
                    FN_OR:   ctrl.kind = K_OR;
                    FN_XOR:  ctrl.kind = K_XOR;
                    FN_NOR:  ctrl.kind = K_NOR;
                    FN_SLT:  begin ctrl.kind = K_SLT; ctrl.subtract = 1'b1; end
                    FN_SLL:  ctrl.kind = K_SHL;
                    FN_SRL:  ctrl.kind = K_SHR;
                    FN_SRA:  ctrl.kind = K_SHRA;
                    default: ctrl.kind = K_NONE;
                endcase
            end
            OPC_ADDI: begin
                ctrl.kind = K_ARITH; ctrl.use_imm = 1'b1;
                ctrl.imm_sext = 1'b1; ctrl.trap_en = 1'b1;
            end
            OPC_ADDIU: begin
                ctrl.kind = K_ARITH; ctrl.use_imm = 1'b1; ctrl.imm_sext = 1'b1;
            end
            OPC_SLTI: begin
                ctrl.kind = K_SLT; ctrl.use_imm = 1'b1;
                ctrl.imm_sext = 1'b1; ctrl.subtract = 1'b1;
            end
            OPC_ANDI: begin ctrl.kind = K_AND; ctrl.use_imm = 1'b1; end
            OPC_ORI:  begin ctrl.kind = K_OR;  ctrl.use_imm = 1'b1; end
            OPC_LUI:  ctrl.kind = K_HIGH;
            default:  ctrl.kind = K_NONE;
        endcase
    end
endmodule

// File: rtl/alu_addsub.sv
// Shared adder/subtractor for arithmetic and signed compare.
// Produces the wrapped sum, the signed-less-than flag and a gated trap.
module alu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         subtract,
    input  logic         trap_en,
    output logic [W-1:0] sum,
    output logic         less,
    output logic         trap
);
    logic [W-1:0] b_eff;
    logic         ovf;

    // Purpose: one carry chain serves add, subtract and compare.
    always_comb begin
        b_eff = subtract ? ~b : b;
        sum   = a + b_eff + W'(subtract);
        ovf   = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
        less  = sum[W-1] ^ ovf;
        trap  = trap_en & ovf;
    end
endmodule

// File: rtl/alu_shifter.sv
// Logarithmic shifter: left, logical right or arithmetic right.
// One stage per shift-amount bit, selected by generate.
module alu_shifter #(
    parameter int W  = 32,
    parameter int SW = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  logic [SW-1:0] amount,
    input  logic          right,
    input  logic          arith,
    output logic [W-1:0]  dout
);
    logic [W-1:0] stage [SW+1];
    logic         fill;

    assign stage[0] = din;
    assign fill     = arith & din[W-1];

    for (genvar i = 0; i < SW; i++) begin : g_stage
        localparam int STEP = 1 << i;
        logic [W-1:0] top_mask;
        // Purpose: conditionally move the word by 2^i places.
        always_comb begin
            top_mask = fill ? ~({W{1'b1}} >> STEP) : '0;
            if (!amount[i])
                stage[i+1] = stage[i];
            else if (right)
                stage[i+1] = (stage[i] >> STEP) | top_mask;
            else
                stage[i+1] = stage[i] << STEP;
        end
    end

    assign dout = stage[SW];
endmodule

// File: rtl/int_alu_trap.sv
// Combinational integer ALU with a signed-overflow trap request.
// Assumes the caller latches outputs; result_valid marks trapped results.
module int_alu_trap
    import alu_pkg::*;
#(
    parameter int W     = 32,
    parameter int IMM_W = 16,
    parameter int SH_W  = $clog2(W)
) (
    input  logic [OPC_W-1:0] opcode,
    input  logic [OPC_W-1:0] funct,
    input  logic [SH_W-1:0]  shamt,
    input  logic [W-1:0]     opnd_a,
    input  logic [W-1:0]     opnd_b,
    input  logic [IMM_W-1:0] imm,
    output logic [W-1:0]     result,
    output logic             trap_req,
    output logic             result_valid
);
    localparam int EXT_W = W - IMM_W;

    alu_ctrl_t    ctrl;
    logic [W-1:0] imm_ext;
    logic [W-1:0] opnd2;
    logic [W-1:0] sum;
    logic         less;
    logic         trap;
    logic [W-1:0] shifted;

    alu_decode u_decode (
        .opcode (opcode),
        .funct  (funct),
        .ctrl   (ctrl)
    );

    // Purpose: pick the second operand and extend the immediate.
    always_comb begin
        imm_ext = ctrl.imm_sext ? {{EXT_W{imm[IMM_W-1]}}, imm}
                                : {{EXT_W{1'b0}}, imm};
        opnd2   = ctrl.use_imm ? imm_ext : opnd_b;
    end

    alu_addsub #(.W(W)) u_addsub (
        .a        (opnd_a),
        .b        (opnd2),
        .subtract (ctrl.subtract),
        .trap_en  (ctrl.trap_en),
        .sum      (sum),
        .less     (less),
        .trap     (trap)
    );

    alu_shifter #(.W(W), .SW(SH_W)) u_shifter (
        .din    (opnd_b),
        .amount (shamt),
        .right  (ctrl.kind == K_SHR || ctrl.kind == K_SHRA),
        .arith  (ctrl.kind == K_SHRA),
        .dout   (shifted)
    );

    // Purpose: select the result of the decoded operation.
    always_comb begin
        unique case (ctrl.kind)
            K_ARITH: result = sum;
            K_AND:   result = opnd_a & opnd2;
            K_OR:    result = opnd_a | opnd2;
            K_XOR:   result = opnd_a ^ opnd2;
            K_NOR:   result = ~(opnd_a | opnd2);
            K_SLT:   result = {{(W-1){1'b0}}, less};
            K_HIGH:  result = {imm, {EXT_W{1'b0}}};
            K_SHL, K_SHR, K_SHRA: result = shifted;
            default: result = '0;
        endcase
        trap_req     = trap;
        result_valid = ~trap;
    end

    // Purpose: guard cross-module relations of decode, adder and shifter.
    always_comb begin
        if (!$isunknown({opcode, funct, shamt, opnd_a, opnd_b, imm})) begin
            if (opcode != OPC_ADDI && !(opcode == OPC_SPECIAL &&
                (funct == FN_ADD || funct == FN_SUB)))
                AST_NO_OVERFLOW: assert (!trap_req) else $error("trap on non-trapping op"); // R2
            if (opcode == OPC_SLTI || (opcode == OPC_SPECIAL && funct == FN_SLT))
                AST_SLT_BOOL: assert (result[W-1:1] == '0) else $error("compare not boolean"); // R6
            if (opcode == OPC_LUI)
                AST_HIGH_LOW_ZERO: assert (result[IMM_W-1:0] == '0) else $error("low half not zero"); // R7
            if (opcode == OPC_SPECIAL && shamt == '0 &&
                (funct == FN_SLL || funct == FN_SRL || funct == FN_SRA))
                AST_SHIFT_IDENT: assert (result == opnd_b) else $error("zero shift altered value"); // R8
            if (opcode == OPC_SPECIAL && funct == '0 && shamt == '0)
                AST_ZERO_WORD: assert (result == opnd_b && result_valid) else $error("zero word not a no-op"); // R10
        end
    end
endmodule

// File: tb/int_alu_trap_bench.sv
module int_alu_trap_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  opcode = '0, funct = '0;
    logic [4:0]  shamt = '0;
    logic [31:0] opnd_a = '0, opnd_b = '0;
    logic [15:0] imm = '0;
    logic [31:0] result;
    logic        trap_req, result_valid;
    int          n_chk = 0, n_bad = 0;

    always #2 clk = ~clk;

    int_alu_trap u_int_alu_trap (
        .opcode(opcode), .funct(funct), .shamt(shamt), .opnd_a(opnd_a),
        .opnd_b(opnd_b), .imm(imm), .result(result), .trap_req(trap_req),
        .result_valid(result_valid)
    );

    function automatic logic [31:0] corner(int i);
        case (i)
            0: return 32'h0000_0000;  1: return 32'h0000_0001;
            2: return 32'h0000_0002;  3: return 32'hFFFF_FFFF;
            4: return 32'h7FFF_FFFF;  5: return 32'h8000_0000;
            6: return 32'h8000_0001;  7: return 32'h7FFF_FFFE;
            8: return 32'h1234_5678;  9: return 32'hDEAD_BEEF;
            10: return 32'h0000_FFFF; default: return 32'hFFFF_0000;
        endcase
    endfunction

    function automatic logic [15:0] imm_corner(int i);
        case (i)
            0: return 16'h0000; 1: return 16'h0001; 2: return 16'h7FFF;
            3: return 16'h8000; 4: return 16'hFFFF; default: return 16'hA5C3;
        endcase
    endfunction

    function automatic logic ovf_of(longint v);
        return (v > 64'sd2147483647) || (v < -64'sd2147483648);
    endfunction

    task automatic apply(logic [5:0] op, logic [5:0] fn, logic [4:0] sh,
                         logic [31:0] a, logic [31:0] b, logic [15:0] im);
        @(posedge clk); #1;
        opcode = op; funct = fn; shamt = sh; opnd_a = a; opnd_b = b; imm = im;
        @(negedge clk);
    endtask

    task automatic check(string req, logic [31:0] er, logic et);
        n_chk++;
        if (result !== er || trap_req !== et || result_valid !== !et) begin
            n_bad++;
            $display("FAIL %s op=%h fn=%h sh=%0d a=%h b=%h imm=%h: got %h/%b/%b exp %h/%b/%b",
                     req, opcode, funct, shamt, opnd_a, opnd_b, imm,
                     result, trap_req, result_valid, er, et, !et);
        end
    endtask

    initial begin
        #800000;
        n_bad++;
        $display("FAIL watchdog: run did not finish, got timeout exp completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R10: all-zero word at start passes opnd_b through
        apply(6'h00, 6'h00, 5'd0, 32'h0, 32'h0, 16'h0);
        check("R10", 32'h0, 1'b0);
        apply(6'h00, 6'h00, 5'd0, 32'hCAFE_F00D, 32'h5555_AAAA, 16'hFFFF);
        check("R10", 32'h5555_AAAA, 1'b0);

        // R1 R2 R4 R6 R9: every pair of corner operands
        for (int i = 0; i < 12; i++) begin
            for (int j = 0; j < 12; j++) begin
                logic [31:0] a, b;
                longint sa, sd;
                a = corner(i); b = corner(j);
                sa = longint'($signed(a)) + longint'($signed(b));
                sd = longint'($signed(a)) - longint'($signed(b));
                apply(6'h00, 6'h20, 5'd7, a, b, 16'h1234); check("R1/R2/R9 add", a + b, ovf_of(sa));
                apply(6'h00, 6'h21, 5'd0, a, b, 16'h0);    check("R1/R2 addu", a + b, 1'b0);
                apply(6'h00, 6'h22, 5'd0, a, b, 16'h0);    check("R1/R2/R9 sub", a - b, ovf_of(sd));
                apply(6'h00, 6'h23, 5'd0, a, b, 16'h0);    check("R1/R2 subu", a - b, 1'b0);
                apply(6'h00, 6'h24, 5'd0, a, b, 16'h0);    check("R4 and", a & b, 1'b0);
                apply(6'h00, 6'h25, 5'd0, a, b, 16'h0);    check("R4 or", a | b, 1'b0);
                apply(6'h00, 6'h26, 5'd0, a, b, 16'h0);    check("R4 xor", a ^ b, 1'b0);
                apply(6'h00, 6'h27, 5'd0, a, b, 16'h0);    check("R4 nor", ~(a | b), 1'b0);
                apply(6'h00, 6'h2A, 5'd0, a, b, 16'h0);
                check("R6 slt", {31'b0, longint'($signed(a)) < longint'($signed(b))}, 1'b0);
            end
        end

        // R3 R5 R6 R7: corner operands against corner immediates
        for (int i = 0; i < 12; i++) begin
            for (int k = 0; k < 6; k++) begin
                logic [31:0] a, se, ze;
                longint s;
                a  = corner(i);
                se = {{16{imm_corner(k)[15]}}, imm_corner(k)};
                ze = {16'h0, imm_corner(k)};
                s  = longint'($signed(a)) + longint'($signed(se));
                apply(6'h08, 6'h3F, 5'd3, a, 32'hFFFF_FFFF, imm_corner(k)); check("R3/R9 addi", a + se, ovf_of(s));
                apply(6'h09, 6'h3F, 5'd3, a, 32'hFFFF_FFFF, imm_corner(k)); check("R3 addiu", a + se, 1'b0);
                apply(6'h0C, 6'h00, 5'd0, a, 32'hFFFF_FFFF, imm_corner(k)); check("R5 andi", a & ze, 1'b0);
                apply(6'h0D, 6'h00, 5'd0, a, 32'h0, imm_corner(k));         check("R5 ori", a | ze, 1'b0);
                apply(6'h0A, 6'h00, 5'd0, a, 32'h0, imm_corner(k));
                check("R6 slti", {31'b0, longint'($signed(a)) < longint'($signed(se))}, 1'b0);
                apply(6'h0F, 6'h20, 5'd9, a, 32'h7FFF_FFFF, imm_corner(k)); check("R7 lui", {imm_corner(k), 16'h0}, 1'b0);
            end
        end

        // R8: every shift amount over corner sources
        for (int i = 0; i < 12; i++) begin
            for (int s = 0; s < 32; s++) begin
                logic [31:0] b;
                b = corner(i);
                apply(6'h00, 6'h00, 5'(s), 32'h1357_9BDF, b, 16'h0); check("R8 sll", b << s, 1'b0);
                apply(6'h00, 6'h02, 5'(s), 32'h1357_9BDF, b, 16'h0); check("R8 srl", b >> s, 1'b0);
                apply(6'h00, 6'h03, 5'(s), 32'h1357_9BDF, b, 16'h0);
                check("R8 sra", b[31] ? ~((~b) >> s) : (b >> s), 1'b0);
            end
        end

        // R11: unused opcodes and function codes give zero, no trap
        for (int c = 0; c < 64; c++) begin
            logic [5:0] cc;
            cc = 6'(c);
            if (!(cc inside {6'h00, 6'h08, 6'h09, 6'h0A, 6'h0C, 6'h0D, 6'h0F})) begin
                apply(cc, 6'h20, 5'd0, 32'h7FFF_FFFF, 32'h1, 16'h7FFF); check("R11 opcode", 32'h0, 1'b0);
            end
            if (!(cc inside {6'h00, 6'h02, 6'h03, 6'h20, 6'h21, 6'h22, 6'h23,
                             6'h24, 6'h25, 6'h26, 6'h27, 6'h2A})) begin
                apply(6'h00, cc, 5'd4, 32'h7FFF_FFFF, 32'h1, 16'hFFFF); check("R11 funct", 32'h0, 1'b0);
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule